// File: doc/BRIEF.md
# Micro-Spill Acquisition Window Sequencer

This block sits in a central trigger supervisor. It divides each beam spill into a series of shorter acquisition windows for two detector readout systems. Detector A stops on its own when its event memory fills and loses whatever is still in memory when a window closes. Detector B takes exactly one acquisition per window and always reads out when the window ends. Every window therefore has a programmed nominal length and is then stretched until detector A signals memory-full. This way each window yields data from both detectors. After a window closes, the block waits for both busy flags to clear. It then opens the next window at once, provided the spill is still on and no software veto is raised.

All logic runs on one shared fast clock. A divide-by-`DIV` strobe stands for the slow command clock of detector A. Every phase change happens only on an edge where that strobe is high, so window boundaries line up with the slow clock to within one slow period. A window identifier counts closed windows from zero after reset, which keeps the spill numbering of both detectors in step. All pins are plain control and status levels or pulses. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `uspill_seq`

## Requirements
- R1: After reset `phase` is 2'b00 (idle), `acq_window` is 0 and `window_id` is 0. The phase codes are 00 idle, 01 acquisition, 10 extension and 11 readout.
- R2: In idle, once `spill_start` has been seen, a slow tick with both busy flags low and `sw_veto` low moves the block to acquisition and raises `acq_window`.
- R3: Acquisition lasts exactly `len` slow ticks (`len*DIV` fast cycles). The block then enters extension with `acq_window` still high.
- R4: Extension is held until a `mem_full` pulse arrives during extension. A `mem_full` pulse during acquisition has no effect on this.
- R5: Extension ends on the slow tick after that pulse. The block enters readout, `acq_window` drops, and `window_id` increments by one. `window_id` changes at no other time.
- R6: Readout lasts while either `busy_a` or `busy_b` is high.
- R7: When both busy flags are low, the spill is still on and there is no veto, the next acquisition starts on the next slow tick, at most `DIV` cycles later.
- R8: While `sw_veto` is high, no acquisition starts. Readout falls to idle instead, and the block starts again once the veto drops.
- R9: After `spill_end`, the current window completes normally. Readout then goes to idle, and no new window opens until the next `spill_start`.
- R10: A length of zero gives a single window that stays in acquisition until `spill_end`, then goes through extension.
- R11: Every change of `phase` happens on a fast clock edge whose count since reset release is a multiple of `DIV`.
- R12: A write with `len_we` replaces the window length used by later windows. The value after reset is `LEN_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared fast clock |
| rst_n | input | 1 | Active-low reset, start of run |
| spill_start | input | 1 | One-cycle pulse: beam spill begins |
| spill_end | input | 1 | One-cycle pulse: beam spill ends (wins if both pulses arrive together) |
| mem_full | input | 1 | One-cycle pulse: detector A memory full |
| busy_a | input | 1 | Detector A reading out |
| busy_b | input | 1 | Detector B reading out |
| sw_veto | input | 1 | Software veto, level |
| len_we | input | 1 | Write strobe for the window length |
| len_wdata | input | LEN_W | Window length in slow ticks |
| acq_window | output | 1 | Acquisition window, high during acquisition and extension |
| window_id | output | CNT_W | Number of windows closed since reset |
| phase | output | 2 | Current phase code |

## Verification
On every cycle, the assertions check the following. Phase changes happen only on a slow tick. Readout holds while a busy flag is up. Extension holds until memory-full is seen. A veto never lets an acquisition begin. The window identifier moves only when a window closes. Only the bench scenarios can show the exact acquisition length in fast cycles, the tick-aligned spacing measured from reset, and the dead time between the last busy drop and the next window. They also show the full phase and identifier sequence across a veto, an end of spill and a zero-length run.

// File: rtl/uspill_pkg.sv
package uspill_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ACQ  = 2'b01,
    PH_EXT  = 2'b10,
    PH_RDO  = 2'b11
  } phase_e;
endpackage

// File: rtl/uspill_tick_gen.sv
module uspill_tick_gen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // strobe is a single-cycle pulse (R11)
  assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/uspill_len_timer.sv
module uspill_len_timer #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             elapsed
);
  logic [LEN_W-1:0] ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ticks <= '0;
    else if (!run) ticks <= '0;
    else if (tick) ticks <= ticks + 1'b1;
  end

  // the tick that would complete the programmed count
  assign elapsed = (len != '0) && (({1'b0, ticks} + 1'b1) >= {1'b0, len});
endmodule

// File: rtl/uspill_fsm.sv
module uspill_fsm
  import uspill_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             spill_start,
  input  logic             spill_end,
  input  logic             mem_full,
  input  logic             busy_a,
  input  logic             busy_b,
  input  logic             veto,
  input  logic             elapsed,
  input  logic             len_zero,
  output phase_e           state,
  output logic [CNT_W-1:0] win_id
);
  phase_e nxt;
  logic   spill_act;
  logic   rf_seen;
  logic   quiet;

  assign quiet = !busy_a && !busy_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           spill_act <= 1'b0;
    else if (spill_end)   spill_act <= 1'b0;
    else if (spill_start) spill_act <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rf_seen <= 1'b0;
    else if (state != PH_EXT) rf_seen <= 1'b0;
    else if (mem_full)        rf_seen <= 1'b1;
  end

  always_comb begin
    nxt = state;
    if (tick) begin
      unique case (state)
        PH_IDLE: if (spill_act && !veto && quiet) nxt = PH_ACQ;
        PH_ACQ:  if (len_zero ? !spill_act : elapsed) nxt = PH_EXT;
        PH_EXT:  if (rf_seen || mem_full) nxt = PH_RDO;
        PH_RDO:  if (quiet) nxt = (spill_act && !veto) ? PH_ACQ : PH_IDLE;
        default: nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      win_id <= '0;
    end else begin
      state <= nxt;
      if (state == PH_EXT && nxt == PH_RDO) win_id <= win_id + 1'b1;
    end
  end

  assert_phase_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));

  assert_ext_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_EXT && !rf_seen && !mem_full) |=> state == PH_EXT);

  assert_id_only_at_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PH_EXT) |=> $stable(win_id));

  assert_rdo_waits_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_RDO && !quiet) |=> state == PH_RDO);

  assert_veto_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (veto && (state == PH_IDLE || state == PH_RDO)) |=> state != PH_ACQ);

  assert_idle_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE && !spill_act) |=> state == PH_IDLE);
endmodule

// File: rtl/uspill_seq.sv
module uspill_seq
  import uspill_pkg::*;
#(
  parameter int DIV     = 10,
  parameter int LEN_W   = 24,
  parameter int CNT_W   = 16,
  parameter int LEN_RST = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spill_start,
  input  logic             spill_end,
  input  logic             mem_full,
  input  logic             busy_a,
  input  logic             busy_b,
  input  logic             sw_veto,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_wdata,
  output logic             acq_window,
  output logic [CNT_W-1:0] window_id,
  output logic [1:0]       phase
);
  logic             tick;
  logic             elapsed;
  logic [LEN_W-1:0] len_q;
  phase_e           state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= LEN_W'(LEN_RST);
    else if (len_we) len_q <= len_wdata;
  end

  uspill_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  uspill_len_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == PH_ACQ), .tick(tick),
    .len(len_q), .elapsed(elapsed)
  );

  uspill_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .spill_start(spill_start), .spill_end(spill_end), .mem_full(mem_full),
    .busy_a(busy_a), .busy_b(busy_b), .veto(sw_veto),
    .elapsed(elapsed), .len_zero(len_q == '0),
    .state(state), .win_id(window_id)
  );

  assign acq_window = (state == PH_ACQ) || (state == PH_EXT);
  assign phase      = state;
endmodule

// File: tb/tb_uspill_seq.sv
module tb_uspill_seq;
  localparam int DIV = 10, LEN_W = 24, CNT_W = 16;

  logic clk = 0, rst_n = 0;
  logic spill_start = 0, spill_end = 0, mem_full = 0;
  logic busy_a = 0, busy_b = 0, sw_veto = 0, len_we = 0;
  logic [LEN_W-1:0] len_wdata = '0;
  logic acq_window;
  logic [CNT_W-1:0] window_id;
  logic [1:0] phase;

  int checks = 0, errors = 0, ecount = 0;
  logic [CNT_W+1:0] expq[$];
  logic [1:0] prev_ph = 2'b00;
  bit done = 0;

  always #4 clk = ~clk;

  uspill_seq #(.DIV(DIV), .LEN_W(LEN_W), .CNT_W(CNT_W), .LEN_RST(5)) dut (
    .clk(clk), .rst_n(rst_n), .spill_start(spill_start), .spill_end(spill_end),
    .mem_full(mem_full), .busy_a(busy_a), .busy_b(busy_b), .sw_veto(sw_veto),
    .len_we(len_we), .len_wdata(len_wdata),
    .acq_window(acq_window), .window_id(window_id), .phase(phase));

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(logic [1:0] p, int id);
    expq.push_back({p, CNT_W'(id)});
  endtask

  // monitor: scoreboard of phase transitions plus slow-tick alignment
  always @(negedge clk) if (rst_n && !done) begin
    if (phase != prev_ph) begin
      if (expq.size() == 0) chk(0, "R11", "unexpected phase change", phase, prev_ph);
      else begin
        logic [CNT_W+1:0] e;
        e = expq.pop_front();
        chk(phase == e[CNT_W+1:CNT_W], "R5", "phase sequence", phase, e[CNT_W+1:CNT_W]);
        chk(window_id == e[CNT_W-1:0], "R5", "window_id at transition", window_id, e[CNT_W-1:0]);
      end
      chk(ecount % DIV == 0, "R11", "transition off slow tick", ecount % DIV, 0);
    end
    prev_ph = phase;
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", phase, 0);
    finish_run();
  end

  task automatic wait_phase(logic [1:0] p, string req);
    int n = 0;
    while (phase != p && n < 5000) begin @(negedge clk); n++; end
    if (phase != p) chk(0, req, "phase not reached", phase, p);
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_mem_full(bit ba, bit bb);
    mem_full = 1; busy_a = ba; busy_b = bb;
    @(negedge clk); mem_full = 0;
  endtask

  initial begin
    int t0, t1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(phase == 2'b00, "R1", "reset phase", phase, 0);
    chk(acq_window == 0, "R1", "reset window", acq_window, 0);
    chk(window_id == 0, "R1", "reset id", window_id, 0);

    // R12 program length 3
    len_wdata = 3; len_we = 1; @(negedge clk); len_we = 0;

    // Scenario A: first window, extension, readout, immediate restart
    push(2'b01, 0); push(2'b10, 0); push(2'b11, 1); push(2'b01, 1);
    spill_start = 1; @(negedge clk); spill_start = 0;
    wait_phase(2'b01, "R2"); t0 = ecount;
    chk(acq_window == 1, "R2", "window high in acquisition", acq_window, 1);
    idle_cycles(5); pulse_mem_full(0, 0);  // ignored in acquisition (R4)
    wait_phase(2'b10, "R3"); t1 = ecount;
    chk(t1 - t0 == 3 * DIV, "R12", "acquisition length uses written value (R3)", t1 - t0, 3 * DIV);
    chk(acq_window == 1, "R3", "window high in extension", acq_window, 1);
    idle_cycles(40);
    chk(phase == 2'b10, "R4", "extension held without mem_full", phase, 2);
    pulse_mem_full(1, 1);
    wait_phase(2'b11, "R5");
    chk(acq_window == 0, "R5", "window low in readout", acq_window, 0);
    chk(window_id == 1, "R5", "id after first close", window_id, 1);
    busy_b = 0; idle_cycles(30);
    chk(phase == 2'b11, "R6", "readout held by busy_a", phase, 3);
    busy_a = 0; t0 = ecount;
    wait_phase(2'b01, "R7"); t1 = ecount;
    chk(t1 - t0 > 0 && t1 - t0 <= DIV, "R7", "restart latency", t1 - t0, DIV);

    // Scenario B: veto during window 1
    push(2'b10, 1); push(2'b11, 2); push(2'b00, 2); push(2'b01, 2);
    sw_veto = 1;
    wait_phase(2'b10, "R3");
    pulse_mem_full(1, 1);
    wait_phase(2'b11, "R5");
    idle_cycles(15); busy_a = 0; busy_b = 0;
    wait_phase(2'b00, "R8");
    idle_cycles(40);
    chk(phase == 2'b00, "R8", "veto holds idle", phase, 0);
    sw_veto = 0;
    wait_phase(2'b01, "R8");
    chk(acq_window == 1, "R8", "start after veto drops", acq_window, 1);

    // Scenario C: end of spill during window 2
    push(2'b10, 2); push(2'b11, 3); push(2'b00, 3);
    spill_end = 1; @(negedge clk); spill_end = 0;
    chk(phase == 2'b01, "R9", "window kept after spill end", phase, 1);
    wait_phase(2'b10, "R9");
    pulse_mem_full(1, 0);
    wait_phase(2'b11, "R9");
    idle_cycles(20); busy_a = 0;
    wait_phase(2'b00, "R9");
    idle_cycles(60);
    chk(phase == 2'b00 && acq_window == 0, "R9", "no window after spill end", phase, 0);
    chk(window_id == 3, "R5", "id after three windows", window_id, 3);

    // Scenario D: zero length, single window for the whole spill
    len_wdata = 0; len_we = 1; @(negedge clk); len_we = 0;
    push(2'b01, 3); push(2'b10, 3); push(2'b11, 4); push(2'b00, 4);
    spill_start = 1; @(negedge clk); spill_start = 0;
    wait_phase(2'b01, "R10");
    idle_cycles(300);
    chk(phase == 2'b01, "R10", "zero length stays in acquisition", phase, 1);
    spill_end = 1; @(negedge clk); spill_end = 0;
    wait_phase(2'b10, "R10");
    pulse_mem_full(0, 0);
    wait_phase(2'b00, "R10");
    chk(window_id == 4, "R10", "single window counted", window_id, 4);

    idle_cycles(5);
    chk(expq.size() == 0, "R5", "expected transitions left", expq.size(), 0);
    finish_run();
  end
endmodule